// File: doc/BRIEF.md
# Branch and Operand Address Generator

This unit sits beside the decoder of a small 16-bit processor with a 24-bit address space and turns an instruction's address or displacement field into a 24-bit effective address. It covers several groups of modes. Immediate data is zero-extended, and so are bit-number and trap-vector selectors. Absolute addresses are 8, 16 or 24 bits wide. Branch targets can be relative to the program counter, and jump targets can be fetched through a pointer held in low memory.

Every mode except the pointer fetch answers in the same cycle as its start strobe. In that mode the unit first places a 32-bit read at a pointer address in page zero and holds it until the memory answers. It then drops the top byte of the returned word and presents the low 24 bits as the jump target. Branch targets with bit 0 set are flagged as misaligned, so that the exception logic can act on them.

Top module: `target_addr_unit`

## Requirements
- R1: Mode 0 returns field[7:0] zero-extended, and mode 1 returns field[15:0] zero-extended.
- R2: Mode 2 (bit number) returns field[2:0] zero-extended. Mode 3 (trap vector) returns TRAP_BASE + 4*field[1:0], where TRAP_BASE defaults to 0x000010.
- R3: Mode 4 (short absolute) returns 0x00FF00 | field[7:0], so it reaches only 0xFF00..0xFFFF.
- R4: Mode 5 returns field[15:0] zero-extended, and mode 6 returns field[23:0].
- R5: Mode 7 returns next_pc plus field[7:0] sign-extended, modulo 2^24.
- R6: Mode 8 returns next_pc plus field[15:0] sign-extended, modulo 2^24.
- R7: misalign is high only together with done. It is high exactly when the result of a branch mode (7, 8 or 9) has bit 0 set, and never for modes 0 to 6.
- R8: For every mode other than 9, a start while idle raises done and the result in that same cycle.
- R9: A start in mode 9 while idle sets busy. From the next cycle mem_req is high with mem_addr = {16'h0000, field[7:0]}, and both stay unchanged until mem_rvalid.
- R10: In the cycle after mem_rvalid, done pulses for one cycle with result = mem_rdata[23:0]. Bits 31:24 of the returned word have no effect, and mem_req is low.
- R11: While busy is high, start has no effect: done stays low during the wait, and neither the pointer address nor the final target changes.
- R12: While reset is held and just after it, done, busy, misalign and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an address for the current mode |
| mode | input | 4 | Addressing mode code (0 to 9) |
| field | input | 24 | Displacement, immediate or address field |
| next_pc | input | 24 | Address of the instruction after this one |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | Result valid this cycle |
| result | output | 24 | Effective address or target |
| misalign | output | 1 | Branch target is odd |
| mem_req | output | 1 | 32-bit read request |
| mem_addr | output | 24 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench tests the extreme displacements 0x80 and 0x7F, and 0x8000 as well. A design that zero-extended them would jump forward instead of back. It also runs a sum that wraps past 0xFFFFFF, which a wider adder would carry out of range. The pointer word has a non-zero top byte, so a design that kept that byte would give a wrong target. Starts issued during the memory wait would either show up as a stray done or change the held read address. The short absolute address is checked at 0x00 and 0xFF, which catches a missing or misplaced upper page.

// File: rtl/tau_pkg.sv
package tau_pkg;
  typedef enum logic [3:0] {
    M_IMM8   = 4'd0,
    M_IMM16  = 4'd1,
    M_BITNUM = 4'd2,
    M_TRAP   = 4'd3,
    M_ABS8   = 4'd4,
    M_ABS16  = 4'd5,
    M_ABS24  = 4'd6,
    M_REL8   = 4'd7,
    M_REL16  = 4'd8,
    M_PTR    = 4'd9
  } tau_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_DONE = 2'd2
  } tau_state_e;
endpackage

// File: rtl/tau_calc.sv
module tau_calc
  import tau_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int FIELD_W   = 24,
  parameter logic [ADDR_W-1:0] TRAP_BASE = 24'h000010
) (
  input  tau_mode_e          mode,
  input  logic [FIELD_W-1:0] field,
  input  logic [ADDR_W-1:0]  next_pc,
  output logic [ADDR_W-1:0]  addr,
  output logic               is_branch
);
  localparam int HI8  = ADDR_W - 8;
  localparam int HI16 = ADDR_W - 16;

  logic [ADDR_W-1:0] sx8, sx16, trap_off;

  always_comb begin
    sx8      = {{HI8{field[7]}}, field[7:0]};
    sx16     = {{HI16{field[15]}}, field[15:0]};
    trap_off = {{(ADDR_W-4){1'b0}}, field[1:0], 2'b00};
    is_branch = 1'b0;
    case (mode)
      M_IMM8:   addr = {{HI8{1'b0}}, field[7:0]};
      M_IMM16:  addr = {{HI16{1'b0}}, field[15:0]};
      M_BITNUM: addr = {{(ADDR_W-3){1'b0}}, field[2:0]};
      M_TRAP:   addr = TRAP_BASE + trap_off;
      M_ABS8:   addr = {{HI16{1'b0}}, 8'hFF, field[7:0]};
      M_ABS16:  addr = {{HI16{1'b0}}, field[15:0]};
      M_ABS24:  addr = field[ADDR_W-1:0];
      M_REL8: begin
        addr      = next_pc + sx8;
        is_branch = 1'b1;
      end
      M_REL16: begin
        addr      = next_pc + sx16;
        is_branch = 1'b1;
      end
      default:  addr = '0;
    endcase
  end
endmodule

// File: rtl/tau_ptr_fetch.sv
module tau_ptr_fetch
  import tau_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              fin,
  output logic [ADDR_W-1:0] tgt,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr
);
  tau_state_e        state_q, state_d;
  logic [PTR_W-1:0]  ptr_q;
  logic [ADDR_W-1:0] tgt_q;
  logic              ptr_en, tgt_en;

  always_comb begin
    state_d = state_q;
    ptr_en  = 1'b0;
    tgt_en  = 1'b0;
    case (state_q)
      S_IDLE: if (launch) begin
        state_d = S_WAIT;
        ptr_en  = 1'b1;
      end
      S_WAIT: if (mem_rvalid) begin
        state_d = S_DONE;
        tgt_en  = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= '0;
    else if (tgt_en) tgt_q <= mem_rdata[ADDR_W-1:0];
  end

  assign busy     = (state_q != S_IDLE);
  assign fin      = (state_q == S_DONE);
  assign tgt      = tgt_q;
  assign mem_req  = (state_q == S_WAIT);
  assign mem_addr = {{(ADDR_W-PTR_W){1'b0}}, ptr_q};

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));
  a_r9_ptr_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[ADDR_W-1:PTR_W] == '0);
  a_r10_fin_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_rvalid |=> fin && !mem_req);
  a_r10_fin_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/target_addr_unit.sv
module target_addr_unit
  import tau_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int FIELD_W = 24,
  parameter int DATA_W  = 32,
  parameter int PTR_W   = 8,
  parameter logic [ADDR_W-1:0] TRAP_BASE = 24'h000010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [FIELD_W-1:0] field,
  input  logic [ADDR_W-1:0] next_pc,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] result,
  output logic              misalign,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_q_n;
  tau_mode_e         mode_e;
  logic [ADDR_W-1:0] calc_addr, tgt;
  logic              calc_branch, fin, launch, quick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign mode_e = tau_mode_e'(mode);
  assign launch = start && !busy && (mode_e == M_PTR);
  assign quick  = start && !busy && (mode_e != M_PTR) && rst_q_n;

  tau_calc #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .TRAP_BASE(TRAP_BASE)) u_calc (
    .mode(mode_e), .field(field), .next_pc(next_pc),
    .addr(calc_addr), .is_branch(calc_branch)
  );

  tau_ptr_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_fetch (
    .clk(clk), .rst_n(rst_q_n), .launch(launch), .ptr(field[PTR_W-1:0]),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .fin(fin), .tgt(tgt),
    .mem_req(mem_req), .mem_addr(mem_addr)
  );

  assign done     = fin || quick;
  assign result   = fin ? tgt : calc_addr;
  assign misalign = fin ? tgt[0] : (quick && calc_branch && calc_addr[0]);

  a_r7_misalign_with_done: assert property (@(posedge clk) disable iff (!rst_q_n)
    misalign |-> done);
  a_r7_misalign_odd: assert property (@(posedge clk) disable iff (!rst_q_n)
    misalign |-> result[0]);
  a_r11_no_done_waiting: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_req |-> !done);
  a_r12_quiet_in_reset: assert property (@(posedge clk)
    !rst_q_n |-> !done && !busy && !mem_req);
endmodule

// File: tb/test_target_addr_unit.sv
module test_target_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  mode;
  logic [23:0] field, next_pc;
  logic        busy, done, misalign, mem_req, mem_rvalid;
  logic [23:0] result, mem_addr;
  logic [31:0] mem_rdata;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  target_addr_unit i_target_addr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
    .next_pc(next_pc), .busy(busy), .done(done), .result(result),
    .misalign(misalign), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a one-cycle start and check the same-cycle result (R8).
  task automatic quick(input string req, input logic [3:0] m, input logic [23:0] f,
                       input logic [23:0] pc, input logic [23:0] exp, input logic mis);
    @(negedge clk);
    start = 1'b1; mode = m; field = f; next_pc = pc;
    #1;
    chk({req, " result"}, {8'h0, result}, {8'h0, exp});
    chk("R8 done same cycle", {31'h0, done}, 32'h1);
    chk({"R7 misalign ", req}, {31'h0, misalign}, {31'h0, mis});
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; mode = '0; field = '0; next_pc = '0;
    mem_rvalid = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R12 done in reset", {31'h0, done}, 32'h0);
    chk("R12 busy in reset", {31'h0, busy}, 32'h0);
    chk("R12 req in reset", {31'h0, mem_req}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 misalign after reset", {31'h0, misalign}, 32'h0);
    chk("R12 busy after reset", {31'h0, busy}, 32'h0);
  endtask

  task automatic t_operand_modes;
    quick("R1 imm8", 4'd0, 24'hABCDEF, 24'h0, 24'h0000EF, 1'b0);
    quick("R1 imm16", 4'd1, 24'hABCDEF, 24'h0, 24'h00CDEF, 1'b0);
    quick("R2 bitnum", 4'd2, 24'h0000FF, 24'h0, 24'h000007, 1'b0);
    quick("R2 trap3", 4'd3, 24'h000003, 24'h0, 24'h00001C, 1'b0);
    quick("R2 trap0", 4'd3, 24'h0000FC, 24'h0, 24'h000010, 1'b0);
    quick("R3 abs8 low", 4'd4, 24'h123400, 24'h0, 24'h00FF00, 1'b0);
    quick("R3 abs8 high", 4'd4, 24'h0000FF, 24'h0, 24'h00FFFF, 1'b0);
    quick("R4 abs16", 4'd5, 24'hFF8001, 24'h0, 24'h008001, 1'b0);
    quick("R4 abs24", 4'd6, 24'hFF8001, 24'h0, 24'hFF8001, 1'b0);
  endtask

  task automatic t_relative;
    quick("R5 rel8 back", 4'd7, 24'h000080, 24'h001000, 24'h000F80, 1'b0);
    quick("R5 rel8 fwd", 4'd7, 24'h00007E, 24'h001000, 24'h00107E, 1'b0);
    quick("R5 rel8 odd", 4'd7, 24'h00007F, 24'h001000, 24'h00107F, 1'b1);
    quick("R5 rel8 wrap", 4'd7, 24'h000020, 24'hFFFFF0, 24'h000010, 1'b0);
    quick("R6 rel16 back", 4'd8, 24'h008000, 24'h010000, 24'h008000, 1'b0);
    quick("R6 rel16 fwd", 4'd8, 24'h007FFF, 24'h010000, 24'h017FFF, 1'b1);
    quick("R6 rel16 wrap", 4'd8, 24'h00FFFE, 24'h000000, 24'hFFFFFE, 1'b0);
  endtask

  // Pointer fetch; extra starts while waiting must be ignored (R11).
  task automatic t_pointer(input logic [7:0] p, input logic [31:0] word, input bit poke);
    @(negedge clk);
    start = 1'b1; mode = 4'd9; field = {16'hAAAA, p};
    #1;
    chk("R8 no done on ptr start", {31'h0, done}, 32'h0);
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy", {31'h0, busy}, 32'h1);
    chk("R9 req", {31'h0, mem_req}, 32'h1);
    chk("R9 req addr", {8'h0, mem_addr}, {24'h0, p});
    if (poke) begin
      start = 1'b1; mode = 4'd4; field = 24'h000033;
      #1;
      chk("R11 no done while busy", {31'h0, done}, 32'h0);
      @(negedge clk);
      mode = 4'd9; field = 24'h000077;
      @(negedge clk);
      start = 1'b0;
    end
    repeat (2) @(negedge clk);
    chk("R9 req held", {31'h0, mem_req}, 32'h1);
    chk("R11 addr unchanged", {8'h0, mem_addr}, {24'h0, p});
    mem_rvalid = 1'b1; mem_rdata = word;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = 32'hDEADBEEF;
    chk("R10 done", {31'h0, done}, 32'h1);
    chk("R10 target", {8'h0, result}, {8'h0, word[23:0]});
    chk("R7 ptr misalign", {31'h0, misalign}, {31'h0, word[0]});
    chk("R10 req dropped", {31'h0, mem_req}, 32'h0);
    @(negedge clk);
    chk("R10 done one cycle", {31'h0, done}, 32'h0);
    chk("R10 idle", {31'h0, busy}, 32'h0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_operand_modes();
        t_relative();
        t_pointer(8'h00, 32'hFF123456, 1'b0);
        t_pointer(8'hFC, 32'h5A00ABC1, 1'b1);
      end
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule